// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block watches up to 32 general-purpose input pins of one port and turns configured pin activity into interrupt requests. A simple synchronous register bus sets four configuration words: a per-pin enable, a per-pin level/edge selector, a per-pin polarity and a per-pin any-change selector. The same bus gives access to the pending flags and to the synchronised pin values.

Each pin passes through a two-flop synchroniser. A history flop follows the synchroniser, so edges are found by comparing the current synchronised sample with the sample from one cycle earlier. A detected condition on an enabled pin latches a pending flag. Software clears a flag by writing a one to its bit. The port drives two request lines. Line 0 covers the lower half of the pins and line 1 covers the upper half.

Writes take effect on the clock edge where the write enable is sampled high. Read data follows the address combinationally within the same cycle.

Top module: `gpio_irq_detector`

## Requirements
- R1: After reset, all configuration words and the pending word read as 0, and both request lines are low.
- R2: The enable (address 0), mode (address 1), polarity (address 2) and any-change (address 3) words read back the last value written. Unmapped addresses 6 and 7 read as 0.
- R3: Address 5 returns the synchronised pins. A pin change made before a clock edge is not yet visible after that edge, and is visible after the second edge.
- R4: In edge mode (mode bit 0, any-change bit 0), polarity 1 selects rising edges and polarity 0 selects falling edges. The pending bit is set at the third clock edge after the pin change.
- R5: In edge mode with the any-change bit set to 1, both rising and falling edges set the pending bit, whatever the polarity bit holds.
- R6: In level mode (mode bit 1), the pending bit is set while the pin matches the polarity: 1 means active-high and 0 means active-low. The any-change bit has no effect in this mode.
- R7: A pin whose enable bit is 0 never sets its pending bit. A pending bit whose enable bit is 0 does not drive a request line.
- R8: Writing to the pending word (address 4) clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R9: If a detection on an enabled pin and a clear of that bit happen in the same cycle, the bit stays set. A level that is still active therefore keeps its flag set through a clear.
- R10: irq[0] is the OR over pins 0 to 15 of (pending AND enable). irq[1] is the same OR over pins 16 to 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pin_i | input | 32 | Raw pin levels, asynchronous to clk |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data for bus_addr_i |
| irq_o | output | 2 | Interrupt request lines, lower and upper pin halves |

## Verification
A corrupted configuration bit shows up at once in a read of its address. On the next qualifying pin change it also appears as a wrong pending bit, three clock edges after that change. A wrong pending flag is visible on the pending read in the same cycle. It also reaches the request line of its pin half in that cycle, provided the pin is enabled. The sweep gives every pin one of eight mode/polarity/any-change combinations and runs all four transition kinds across them. A detector that decodes any one combination wrongly therefore produces a mismatched bit in the pending word.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    ADDR_ENABLE = 3'd0,
    ADDR_MODE   = 3'd1,
    ADDR_POL    = 3'd2,
    ADDR_ANY    = 3'd3,
    ADDR_PEND   = 3'd4,
    ADDR_INPUT  = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] meta_q, sync_q, prev_q;
  logic [W-1:0] meta_n, sync_n, prev_n;

  always_comb begin
    meta_n = pin_i;
    sync_n = meta_q;
    prev_n = sync_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= meta_n;
      sync_q <= sync_n;
      prev_q <= prev_n;
    end
  end

  assign sync_o = sync_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] sync_i,
  input  logic [W-1:0] prev_i,
  input  logic [W-1:0] mode_i,
  input  logic [W-1:0] pol_i,
  input  logic [W-1:0] any_i,
  output logic [W-1:0] evt_o
);
  for (genvar p = 0; p < W; p++) begin : g_pin
    logic rise, fall, lvl_hit, edge_hit;
    always_comb begin
      rise     = sync_i[p] & ~prev_i[p];
      fall     = ~sync_i[p] & prev_i[p];
      lvl_hit  = (sync_i[p] == pol_i[p]);
      if (any_i[p])
        edge_hit = rise | fall;
      else if (pol_i[p])
        edge_hit = rise;
      else
        edge_hit = fall;
      evt_o[p] = mode_i[p] ? lvl_hit : edge_hit;
    end
  end
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      rdata_o,
  input  logic [W-1:0]      evt_i,
  input  logic [W-1:0]      sync_i,
  output logic [W-1:0]      en_o,
  output logic [W-1:0]      mode_o,
  output logic [W-1:0]      pol_o,
  output logic [W-1:0]      any_o,
  output logic [W-1:0]      pend_o
);
  logic [W-1:0] en_q, mode_q, pol_q, any_q, pend_q;
  logic [W-1:0] en_n, mode_n, pol_n, any_n, pend_n;
  logic [W-1:0] clr;
  logic [W-1:0] hit;

  always_comb begin
    en_n   = en_q;
    mode_n = mode_q;
    pol_n  = pol_q;
    any_n  = any_q;
    clr    = '0;
    if (we_i) begin
      case (addr_i)
        ADDR_ENABLE: en_n   = wdata_i;
        ADDR_MODE:   mode_n = wdata_i;
        ADDR_POL:    pol_n  = wdata_i;
        ADDR_ANY:    any_n  = wdata_i;
        ADDR_PEND:   clr    = wdata_i;
        default:     ;
      endcase
    end
    hit    = evt_i & en_q;
    pend_n = (pend_q & ~clr) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      mode_q <= '0;
      pol_q  <= '0;
      any_q  <= '0;
      pend_q <= '0;
    end else begin
      en_q   <= en_n;
      mode_q <= mode_n;
      pol_q  <= pol_n;
      any_q  <= any_n;
      pend_q <= pend_n;
    end
  end

  always_comb begin
    case (addr_i)
      ADDR_ENABLE: rdata_o = en_q;
      ADDR_MODE:   rdata_o = mode_q;
      ADDR_POL:    rdata_o = pol_q;
      ADDR_ANY:    rdata_o = any_q;
      ADDR_PEND:   rdata_o = pend_q;
      ADDR_INPUT:  rdata_o = sync_i;
      default:     rdata_o = '0;
    endcase
  end

  assign en_o   = en_q;
  assign mode_o = mode_q;
  assign pol_o  = pol_q;
  assign any_o  = any_q;
  assign pend_o = pend_q;

  // R2: a configuration write is held afterwards
  a_r2_enable_written: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && addr_i == ADDR_ENABLE) |=> (en_q == $past(wdata_i)));
  a_r2_mode_written: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && addr_i == ADDR_MODE) |=> (mode_q == $past(wdata_i)));

  // R7: a disabled, clear flag cannot become set
  a_r7_disabled_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    (|(~en_q & ~pend_q)) |=> ((pend_q & $past(~en_q & ~pend_q)) == '0));

  // R8: a cleared bit without an enabled event drops
  a_r8_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr & ~(evt_i & en_q))) |=> ((pend_q & $past(clr & ~(evt_i & en_q))) == '0));

  // R8: bits not written as 1 keep their set state
  a_r8_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pend_q & ~clr)) |=> ((pend_q & $past(pend_q & ~clr)) == $past(pend_q & ~clr)));

  // R9: an enabled event always leaves its flag set
  a_r9_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt_i & en_q)) |=> ((pend_q & $past(evt_i & en_q)) == $past(evt_i & en_q)));
endmodule

// File: rtl/gpio_irq_lines.sv
module gpio_irq_lines #(
  parameter int unsigned W      = 32,
  parameter int unsigned NLINES = 2
) (
  input  logic [W-1:0]      pend_i,
  input  logic [W-1:0]      en_i,
  output logic [NLINES-1:0] irq_o
);
  localparam int unsigned GRP = W / NLINES;

  logic [W-1:0] live;
  assign live = pend_i & en_i;

  for (genvar l = 0; l < NLINES; l++) begin : g_line
    assign irq_o[l] = |live[l*GRP +: GRP];
  end
endmodule

// File: rtl/gpio_irq_detector.sv
module gpio_irq_detector
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned NLINES = 2
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic [NPINS-1:0]  pin_i,
  input  logic              bus_we_i,
  input  logic [REG_AW-1:0] bus_addr_i,
  input  logic [NPINS-1:0]  bus_wdata_i,
  output logic [NPINS-1:0]  bus_rdata_o,
  output logic [NLINES-1:0] irq_o
);
  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [NPINS-1:0] sync, prev, evt;
  logic [NPINS-1:0] en, mode, pol, any, pend;

  gpio_irq_sync #(.W(NPINS)) u_sync (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .pin_i  (pin_i),
    .sync_o (sync),
    .prev_o (prev)
  );

  gpio_irq_detect #(.W(NPINS)) u_detect (
    .sync_i (sync),
    .prev_i (prev),
    .mode_i (mode),
    .pol_i  (pol),
    .any_i  (any),
    .evt_o  (evt)
  );

  gpio_irq_regs #(.W(NPINS)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .we_i    (bus_we_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .rdata_o (bus_rdata_o),
    .evt_i   (evt),
    .sync_i  (sync),
    .en_o    (en),
    .mode_o  (mode),
    .pol_o   (pol),
    .any_o   (any),
    .pend_o  (pend)
  );

  gpio_irq_lines #(.W(NPINS), .NLINES(NLINES)) u_lines (
    .pend_i (pend),
    .en_i   (en),
    .irq_o  (irq_o)
  );

  // R1: request lines stay low while the pending word is empty
  a_r1_quiet_when_empty: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (pend == '0) |-> (irq_o == '0));
endmodule

// File: tb/tb_gpio_irq_detector.sv
module tb_gpio_irq_detector;
  localparam int NP = 32;

  logic          clk = 1'b0;
  logic          rst_ni;
  logic [NP-1:0] pin_i;
  logic          bus_we_i;
  logic [2:0]    bus_addr_i;
  logic [NP-1:0] bus_wdata_i;
  logic [NP-1:0] bus_rdata_o;
  logic [1:0]    irq_o;

  int nchk = 0;
  int nerr = 0;

  gpio_irq_detector dut (
    .clk         (clk),
    .rst_ni      (rst_ni),
    .pin_i       (pin_i),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .irq_o       (irq_o)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [NP-1:0] d);
    @(negedge clk);
    bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk);
    bus_we_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [NP-1:0] d);
    bus_addr_i = a;
    #1;
    d = bus_rdata_o;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic exp_bit(input int i, input int k);
    logic m, p, y, o, n;
    m = i[0]; p = i[1]; y = i[2];
    o = i[3] ^ k[0]; n = i[4] ^ k[1];
    if (m)      return (o == p) || (n == p);
    else if (y) return o != n;
    else if (p) return !o && n;
    else        return o && !n;
  endfunction

  initial begin
    #2_000_000;
    nerr++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [NP-1:0] v, mw, pw, yw, ow, nw, ew;
    rst_ni = 1'b0; pin_i = '0; bus_we_i = 1'b0; bus_addr_i = '0; bus_wdata_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(a[2:0], v); chk("R1 reset register", v, '0);
    end
    chk("R1 reset irq", {30'd0, irq_o}, '0);

    // R2 readback
    wr(3'd0, 32'h1234_5678); wr(3'd1, 32'h9ABC_DEF0);
    wr(3'd2, 32'h0F1E_2D3C); wr(3'd3, 32'h4B5A_6978);
    rd(3'd0, v); chk("R2 enable readback", v, 32'h1234_5678);
    rd(3'd1, v); chk("R2 mode readback", v, 32'h9ABC_DEF0);
    rd(3'd2, v); chk("R2 polarity readback", v, 32'h0F1E_2D3C);
    rd(3'd3, v); chk("R2 any-change readback", v, 32'h4B5A_6978);
    rd(3'd6, v); chk("R2 unmapped 6", v, '0);
    rd(3'd7, v); chk("R2 unmapped 7", v, '0);

    // R3 synchroniser latency
    pin_i = 32'hA5A5_3C3C;
    @(posedge clk); @(negedge clk);
    rd(3'd5, v); chk("R3 input after one edge", v, '0);
    @(posedge clk); @(negedge clk);
    rd(3'd5, v); chk("R3 input after two edges", v, 32'hA5A5_3C3C);

    // R4 R5 R6 sweep: pin i takes mode=i[0], pol=i[1], any=i[2]
    for (int k = 0; k < 4; k++) begin
      mw = '0; pw = '0; yw = '0; ow = '0; nw = '0; ew = '0;
      for (int i = 0; i < NP; i++) begin
        mw[i] = i[0]; pw[i] = i[1]; yw[i] = i[2];
        ow[i] = i[3] ^ k[0]; nw[i] = i[4] ^ k[1];
        ew[i] = exp_bit(i, k);
      end
      wr(3'd0, '0);
      pin_i = ow;
      settle();
      wr(3'd1, mw); wr(3'd2, pw); wr(3'd3, yw);
      wr(3'd4, '1);
      wr(3'd0, '1);
      settle();
      pin_i = nw;
      settle();
      rd(3'd4, v); chk($sformatf("R4 R5 R6 sweep pattern %0d pending", k), v, ew);
      chk($sformatf("R10 sweep pattern %0d irq", k), {30'd0, irq_o},
          {30'd0, |ew[31:16], |ew[15:0]});
    end

    // R4 edge timing: rising on pin 3 sets pend on the third edge
    wr(3'd0, '0); wr(3'd1, '0); wr(3'd3, '0); wr(3'd2, '1);
    pin_i = '0; settle();
    wr(3'd4, '1); wr(3'd0, '1);
    pin_i = 32'h0000_0008;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rd(3'd4, v); chk("R4 not set after two edges", v, '0);
    @(posedge clk); @(negedge clk);
    rd(3'd4, v); chk("R4 set after third edge", v, 32'h0000_0008);

    // R7 disabled pins never set
    wr(3'd0, '0); pin_i = '0; settle(); wr(3'd4, '1);
    pin_i = '1; settle();
    rd(3'd4, v); chk("R7 disabled pending", v, '0);
    chk("R7 disabled irq", {30'd0, irq_o}, '0);

    // R10 line split, lower half
    pin_i = '0; settle(); wr(3'd4, '1);
    wr(3'd0, 32'h0000_0020);
    pin_i = 32'h0010_0020; settle();
    rd(3'd4, v); chk("R10 lower pin pending", v, 32'h0000_0020);
    chk("R10 lower line", {30'd0, irq_o}, 32'd1);

    // R10 upper half
    wr(3'd0, '0); pin_i = '0; settle(); wr(3'd4, '1);
    wr(3'd0, 32'h0010_0000);
    pin_i = 32'h0010_0020; settle();
    chk("R10 upper line", {30'd0, irq_o}, 32'd2);
    wr(3'd0, '0);
    rd(3'd4, v); chk("R7 pending kept when disabled", v, 32'h0010_0000);
    chk("R7 irq masked when disabled", {30'd0, irq_o}, '0);

    // R8 write-one-to-clear
    pin_i = '0; settle(); wr(3'd4, '1);
    wr(3'd0, '1);
    pin_i = 32'h0000_F00F; settle();
    wr(3'd4, '0);
    rd(3'd4, v); chk("R8 zero write keeps", v, 32'h0000_F00F);
    wr(3'd4, 32'h0000_000F);
    rd(3'd4, v); chk("R8 one write clears", v, 32'h0000_F000);

    // R9 level stays set through clear
    wr(3'd0, '0); pin_i = '0; settle(); wr(3'd4, '1);
    wr(3'd1, 32'h1); wr(3'd2, 32'h1); wr(3'd0, 32'h1);
    pin_i = 32'h1; settle();
    wr(3'd4, 32'h1);
    rd(3'd4, v); chk("R9 active level survives clear", v, 32'h1);
    pin_i = '0; settle();
    wr(3'd4, 32'h1);
    rd(3'd4, v); chk("R9 inactive level clears", v, '0);

    // R9 edge and clear in the same cycle
    wr(3'd1, '0); wr(3'd3, 32'h2); wr(3'd0, 32'h2);
    pin_i = 32'h2; settle();
    rd(3'd4, v); chk("R5 any-change sets", v, 32'h2);
    @(negedge clk);
    pin_i = 32'h0;
    @(posedge clk); @(posedge clk);
    wr(3'd4, 32'h2);
    rd(3'd4, v); chk("R9 event beats clear", v, 32'h2);
    wr(3'd4, 32'h2);
    rd(3'd4, v); chk("R8 later clear works", v, '0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule